// File: doc/BRIEF.md
# Dual PS/2 Port Register Controller

This block is the register front end for two PS/2 channels: channel 0 serves a keyboard and channel 1 a mouse. A host reaches each channel through its own 256-byte address window. Bit 8 of the address picks the channel and bits [3:2] pick the register within it. The bit-level line protocol lives outside. On the device side, each channel offers a byte receive queue (not-empty flag, head byte, pop strobe) and a transmit strobe that carries one byte.

Each channel has an identity register, a data register, a control byte and a status byte. Reading the data register pops the device queue, and writing it sends a byte to the device. When a channel's loopback control bit is set, a transmitted byte instead lands in a one-byte local buffer and raises that channel's interrupt. Reading the data register then returns that byte and drops the interrupt. In diagnostic mode the status byte also reports line-shadow bits that follow the direction control bits. The interrupts of both channels are ORed onto one output, and each channel's status byte reports that combined level.

A read is requested for one cycle. Its data comes back, qualified by a valid strobe, on the following cycle.

Top module: `ps2_dual_regctl`

## Requirements
- R1: A read at offset 0 returns the channel index: 0x00 for channel 0 (addresses 0x000-0x0FF) and 0x01 for channel 1 (0x100-0x1FF).
- R2: A write at offset 8 stores all 8 bits of the control byte, and a read at offset 8 returns them unchanged. Control bits: 0 enable, 1 loopback, 5 diagnostic, 6 data direction, 7 clock direction.
- R3: In the status byte (offset 12), bits 1, 2, 3 and 5 always read 0. Bits 6 (data shadow) and 7 (clock shadow) read 1, except that with diagnostic set each one reads 0 when its direction bit (6 or 7) is 0.
- R4: With loopback clear, a write at offset 4 pulses that channel's transmit strobe in the same cycle, with the written byte, and no other channel's strobe.
- R5: With loopback clear, a read at offset 4 pops the device queue and returns its head. When the queue is empty, it returns 0x00 and does not pop.
- R6: With loopback set, a write at offset 4 stores the byte in the channel buffer, sets the buffer-full flag and raises the channel interrupt. It sends nothing to the device.
- R7: With loopback set, a read at offset 4 returns the buffered byte, clears the flag and drops the interrupt. It does not pop the device queue.
- R8: Status bit 0 shows the buffer-full flag when loopback is set, and the device queue's not-empty flag otherwise.
- R9: A channel interrupt is its buffer-full flag ORed with its device interrupt input. irq_out is the OR of the channel interrupts, and status bit 4 of both channels shows irq_out.
- R10: Writes at offset 0 (reset slot) and offset 12 change no state and produce no strobe.
- R11: bus_rvalid is high exactly in the cycle after a read request, and it carries the read data.
- R12: A synchronous reset clears the control bytes, the loopback buffers, the flags and the read-valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 9 | Byte address: bit 8 channel, bits [3:2] register |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| dev_rx_nempty | input | 2 | Per-channel device queue not empty |
| dev_rx_data | input | 16 | Per-channel queue head, channel n in bits [8n+7:8n] |
| dev_rx_pop | output | 2 | Per-channel pop strobe |
| dev_tx_stb | output | 2 | Per-channel transmit strobe |
| dev_tx_data | output | 16 | Per-channel transmit byte |
| dev_irq | input | 2 | Per-channel device interrupt level |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions take for granted that the device side never presents a pop-worthy head without its not-empty flag, and that the host issues at most one access per cycle. They also assume dev_irq levels change only while the host is idle. The bench's queue models derive the not-empty flag from their own contents. It issues accesses one at a time from tasks, and it changes interrupt inputs only between accesses, so the properties on pops, strobes and read latency check the design alone.

// File: rtl/ps2dr_pkg.sv
package ps2dr_pkg;
    localparam int BYTE_W = 8;

    // register slot codes taken from address bits [3:2]
    localparam logic [1:0] SLOT_ID_RST = 2'd0;
    localparam logic [1:0] SLOT_DATA   = 2'd1;
    localparam logic [1:0] SLOT_CTRL   = 2'd2;
    localparam logic [1:0] SLOT_STAT   = 2'd3;

    // control byte bit positions
    localparam int CB_ENABLE = 0;
    localparam int CB_LOOP   = 1;
    localparam int CB_DIAG   = 5;
    localparam int CB_DDIR   = 6;
    localparam int CB_CDIR   = 7;

    // status byte bit positions
    localparam int SB_RXNE   = 0;
    localparam int SB_IRQ    = 4;
    localparam int SB_DSHD   = 6;
    localparam int SB_CSHD   = 7;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] lb_buf;
        logic              lb_full;
    } chan_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
        logic              rvalid;
    } rd_state_t;
endpackage

// File: rtl/ps2dr_status.sv
module ps2dr_status
    import ps2dr_pkg::*;
(
    input  logic [BYTE_W-1:0] ctrl_i,
    input  logic              rxne_i,
    input  logic              any_irq_i,
    output logic [BYTE_W-1:0] stat_o
);
    logic diag;

    always_comb begin
        diag   = ctrl_i[CB_DIAG];
        stat_o = '0;
        stat_o[SB_RXNE] = rxne_i;
        stat_o[SB_IRQ]  = any_irq_i;
        stat_o[SB_DSHD] = !(diag && !ctrl_i[CB_DDIR]);
        stat_o[SB_CSHD] = !(diag && !ctrl_i[CB_CDIR]);
    end
endmodule

// File: rtl/ps2dr_chan.sv
module ps2dr_chan
    import ps2dr_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              we_i,
    input  logic [1:0]        slot_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              any_irq_i,
    input  logic              dev_irq_i,
    input  logic              dev_rx_nempty_i,
    input  logic [BYTE_W-1:0] dev_rx_data_i,
    output logic              dev_rx_pop_o,
    output logic              dev_tx_stb_o,
    output logic [BYTE_W-1:0] dev_tx_data_o,
    output logic [BYTE_W-1:0] rd_val_o,
    output logic              irq_o
);
    chan_state_t       st_d, st_q;
    logic              loop_on;
    logic              rxne;
    logic [BYTE_W-1:0] stat_b;

    assign loop_on = st_q.ctrl[CB_LOOP];
    assign rxne    = loop_on ? st_q.lb_full : dev_rx_nempty_i;

    ps2dr_status stat_i (
        .ctrl_i    (st_q.ctrl),
        .rxne_i    (rxne),
        .any_irq_i (any_irq_i),
        .stat_o    (stat_b)
    );

    always_comb begin
        st_d         = st_q;
        dev_rx_pop_o = 1'b0;
        dev_tx_stb_o = 1'b0;
        rd_val_o     = '0;
        if (acc_i && we_i) begin
            case (slot_i)
                SLOT_CTRL: st_d.ctrl = wdata_i;
                SLOT_DATA: begin
                    if (loop_on) begin
                        st_d.lb_buf  = wdata_i;
                        st_d.lb_full = 1'b1;
                    end else begin
                        dev_tx_stb_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (acc_i && !we_i) begin
            case (slot_i)
                SLOT_ID_RST: rd_val_o = BYTE_W'(CHAN_ID);
                SLOT_DATA: begin
                    if (loop_on) begin
                        rd_val_o     = st_q.lb_buf;
                        st_d.lb_full = 1'b0;
                    end else if (dev_rx_nempty_i) begin
                        rd_val_o     = dev_rx_data_i;
                        dev_rx_pop_o = 1'b1;
                    end
                end
                SLOT_CTRL: rd_val_o = st_q.ctrl;
                default:   rd_val_o = stat_b;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dev_tx_data_o = wdata_i;
    assign irq_o         = st_q.lb_full | dev_irq_i;
endmodule

// File: rtl/ps2_dual_regctl.sv
module ps2_dual_regctl
    import ps2dr_pkg::*;
#(
    parameter  int NUM_PORTS = 2,
    parameter  int WIN_BYTES = 256,
    localparam int WIN_BITS  = $clog2(WIN_BYTES),
    localparam int PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W    = WIN_BITS + PSEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BYTE_W-1:0]           bus_wdata,
    output logic [BYTE_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    input  logic [NUM_PORTS-1:0]        dev_rx_nempty,
    input  logic [NUM_PORTS*BYTE_W-1:0] dev_rx_data,
    output logic [NUM_PORTS-1:0]        dev_rx_pop,
    output logic [NUM_PORTS-1:0]        dev_tx_stb,
    output logic [NUM_PORTS*BYTE_W-1:0] dev_tx_data,
    input  logic [NUM_PORTS-1:0]        dev_irq,
    output logic                        irq_out
);
    localparam int SLOT_LSB = 2;

    logic [PSEL_W-1:0]           psel;
    logic [1:0]                  slot;
    logic [NUM_PORTS-1:0]        acc;
    logic [NUM_PORTS-1:0]        chan_irq;
    logic [NUM_PORTS*BYTE_W-1:0] rd_vals;
    logic                        any_irq;
    rd_state_t                   rd_d, rd_q;

    assign psel    = bus_addr[ADDR_W-1 -: PSEL_W];
    assign slot    = bus_addr[SLOT_LSB +: 2];
    assign any_irq = |chan_irq;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chan
        assign acc[i] = bus_req && (psel == PSEL_W'(i));
        ps2dr_chan #(.CHAN_ID(i)) chan_i (
            .clk             (clk),
            .rst_n           (rst_n),
            .acc_i           (acc[i]),
            .we_i            (bus_we),
            .slot_i          (slot),
            .wdata_i         (bus_wdata),
            .any_irq_i       (any_irq),
            .dev_irq_i       (dev_irq[i]),
            .dev_rx_nempty_i (dev_rx_nempty[i]),
            .dev_rx_data_i   (dev_rx_data[i*BYTE_W +: BYTE_W]),
            .dev_rx_pop_o    (dev_rx_pop[i]),
            .dev_tx_stb_o    (dev_tx_stb[i]),
            .dev_tx_data_o   (dev_tx_data[i*BYTE_W +: BYTE_W]),
            .rd_val_o        (rd_vals[i*BYTE_W +: BYTE_W]),
            .irq_o           (chan_irq[i])
        );
    end

    always_comb begin
        rd_d        = '0;
        rd_d.rvalid = bus_req && !bus_we;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (acc[i]) rd_d.rdata = rd_d.rdata | rd_vals[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata  = rd_q.rdata;
    assign bus_rvalid = rd_q.rvalid;
    assign irq_out    = any_irq;
endmodule

// File: rtl/ps2dr_chk.sv
module ps2dr_chk #(
    parameter int NUM_PORTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic                 bus_rvalid,
    input logic [NUM_PORTS-1:0] dev_rx_nempty,
    input logic [NUM_PORTS-1:0] dev_rx_pop,
    input logic [NUM_PORTS-1:0] dev_tx_stb,
    input logic [NUM_PORTS-1:0] dev_irq,
    input logic                 irq_out
);
    // R11
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);
    // R11
    rvalid_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);
    // R5
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rx_pop & ~dev_rx_nempty) == '0);
    // R5
    pop_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_rx_pop) |-> (bus_req && !bus_we));
    // R4
    stb_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_tx_stb) |-> (bus_req && bus_we));
    // R4
    single_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_tx_stb));
    // R5
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_rx_pop));
    // R9
    dev_irq_reaches_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_irq) |-> irq_out);
endmodule

bind ps2_dual_regctl ps2dr_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_rvalid    (bus_rvalid),
    .dev_rx_nempty (dev_rx_nempty),
    .dev_rx_pop    (dev_rx_pop),
    .dev_tx_stb    (dev_tx_stb),
    .dev_irq       (dev_irq),
    .irq_out       (irq_out)
);

// File: tb/ps2_dual_regctl_tb_top.sv
`timescale 1ns/1ps
module ps2_dual_regctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  dev_rx_nempty = '0;
    logic [15:0] dev_rx_data = '0;
    logic [1:0]  dev_rx_pop;
    logic [1:0]  dev_tx_stb;
    logic [15:0] dev_tx_data;
    logic [1:0]  dev_irq = '0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] rxq0[$];
    logic [7:0] rxq1[$];
    logic [7:0] tx0[$];
    logic [7:0] tx1[$];
    int pops0 = 0;
    int pops1 = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    ps2_dual_regctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .dev_rx_nempty(dev_rx_nempty),
        .dev_rx_data(dev_rx_data), .dev_rx_pop(dev_rx_pop),
        .dev_tx_stb(dev_tx_stb), .dev_tx_data(dev_tx_data),
        .dev_irq(dev_irq), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // device queue and transmit model
    always @(posedge clk) begin
        if (dev_rx_pop[0] && rxq0.size() > 0) begin void'(rxq0.pop_front()); pops0++; end
        if (dev_rx_pop[1] && rxq1.size() > 0) begin void'(rxq1.pop_front()); pops1++; end
        if (dev_tx_stb[0]) tx0.push_back(dev_tx_data[7:0]);
        if (dev_tx_stb[1]) tx1.push_back(dev_tx_data[15:8]);
        dev_rx_nempty[0] <= rxq0.size() != 0;
        dev_rx_nempty[1] <= rxq1.size() != 0;
        dev_rx_data[7:0]  <= rxq0.size() != 0 ? rxq0[0] : 8'h00;
        dev_rx_data[15:8] <= rxq1.size() != 0 ? rxq1[0] : 8'h00;
    end

    task automatic push_rx(input int ch, input logic [7:0] b);
        if (ch == 0) begin
            rxq0.push_back(b); dev_rx_nempty[0] = 1'b1; dev_rx_data[7:0] = rxq0[0];
        end else begin
            rxq1.push_back(b); dev_rx_nempty[1] = 1'b1; dev_rx_data[15:8] = rxq1[0];
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (bus_rvalid && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected rvalid", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [8:0] a, input logic [7:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [8:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic report();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        do_reset();
        // reset state
        bus_read(9'h008, 8'h00, "R12 ctrl0 after reset");
        bus_read(9'h00C, 8'hC0, "R3 status0 after reset");
        check(irq_out == 1'b0, "R12 irq after reset", irq_out, 0);
        check(bus_rvalid == 1'b1, "R11 rvalid after read", bus_rvalid, 1);
        @(negedge clk);
        check(bus_rvalid == 1'b0, "R11 rvalid idle", bus_rvalid, 0);
        // identity
        bus_read(9'h000, 8'h00, "R1 id chan0");
        bus_read(9'h1F0, 8'h01, "R1 id chan1");
        // control and shadows
        bus_write(9'h008, 8'hA5);
        bus_read(9'h008, 8'hA5, "R2 ctrl readback");
        bus_read(9'h00C, 8'h80, "R3 diag data dir 0");
        bus_write(9'h008, 8'h21);
        bus_read(9'h00C, 8'h00, "R3 diag both dirs 0");
        bus_write(9'h008, 8'h61);
        bus_read(9'h00C, 8'h40, "R3 diag clk dir 0");
        bus_write(9'h008, 8'h01);
        // transmit without loopback
        bus_write(9'h104, 8'hF4);
        check(tx1.size() == 1 && tx1[0] == 8'hF4, "R4 tx chan1", tx1.size(), 1);
        check(tx0.size() == 0, "R4 no tx chan0", tx0.size(), 0);
        // receive without loopback
        push_rx(0, 8'h1C);
        push_rx(0, 8'h32);
        bus_read(9'h00C, 8'hC1, "R8 rxne from device");
        bus_read(9'h004, 8'h1C, "R5 pop head");
        check(rxq0.size() == 1, "R5 one popped", rxq0.size(), 1);
        bus_read(9'h004, 8'h32, "R5 pop second");
        bus_read(9'h004, 8'h00, "R5 empty read");
        check(pops0 == 2, "R5 no pop when empty", pops0, 2);
        bus_read(9'h00C, 8'hC0, "R8 rxne clear");
        // device interrupt aggregation
        dev_irq = 2'b10;
        @(negedge clk);
        check(irq_out == 1'b1, "R9 dev irq to out", irq_out, 1);
        bus_read(9'h00C, 8'hD0, "R9 combined irq on chan0");
        dev_irq = 2'b00;
        @(negedge clk);
        check(irq_out == 1'b0, "R9 irq released", irq_out, 0);
        // loopback
        bus_write(9'h108, 8'h03);
        push_rx(1, 8'h55);
        bus_write(9'h104, 8'hAB);
        check(tx1.size() == 1, "R6 nothing sent in loopback", tx1.size(), 1);
        check(irq_out == 1'b1, "R6 loopback irq", irq_out, 1);
        bus_read(9'h10C, 8'hD1, "R8 rxne from loop flag");
        bus_read(9'h00C, 8'hD0, "R9 combined irq on chan0");
        bus_read(9'h104, 8'hAB, "R7 loopback read");
        check(irq_out == 1'b0, "R7 irq dropped", irq_out, 0);
        check(rxq1.size() == 1 && pops1 == 0, "R7 no device pop", pops1, 0);
        bus_read(9'h10C, 8'hC0, "R8 loop flag clear with device data");
        // ignored writes
        bus_write(9'h100, 8'hFF);
        bus_write(9'h10C, 8'h00);
        bus_read(9'h108, 8'h03, "R10 ctrl kept");
        check(tx1.size() == 1 && irq_out == 1'b0, "R10 no strobe or flag", tx1.size(), 1);
        // reset clears loopback state
        bus_write(9'h104, 8'h3C);
        check(irq_out == 1'b1, "R6 second loopback irq", irq_out, 1);
        do_reset();
        check(irq_out == 1'b0, "R12 flag cleared", irq_out, 0);
        bus_read(9'h108, 8'h00, "R12 ctrl1 cleared");
        bus_read(9'h10C, 8'hC1, "R8 device rxne after reset");
        bus_read(9'h104, 8'h55, "R5 device byte after reset");
        @(negedge clk);
        check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
        report();
    end
endmodule